// File: doc/BRIEF.md
# Escalating Watchdog Timer with Unlock Key

This block is a watchdog that runs on a slow clock and escalates through four stages. Each stage owns a hold time, counted in slow-clock cycles, and an action code chosen from: do nothing, raise an interrupt, request a CPU reset, request a system reset, or request a full reset. When a stage runs out, its action fires and the count moves on to the next stage that has an action. Stages set to do nothing are skipped. After the last stage the sequence wraps back to stage 0. Software restarts the sequence by writing to the feed address.

The control word, the hold times and the feed address are guarded by a 32-bit unlock key. While the block is locked, writes to those addresses are dropped. The interrupt enable and interrupt clear addresses are always writable. Reset requests leave the block as pulses whose length is set in the control word. A registered read port returns the configuration, the lock state and the interrupt status.

Top module: `esc_watchdog`

## Requirements
- R1: Writing 0x50D83AA1 to address 0 unlocks the block, and writing any other value there locks it. Bit 0 of a read at address 0 returns 1 when unlocked and 0 when locked. The block comes out of reset locked.
- R2: While locked, writes to the control word (address 1), the hold registers (addresses 2 to 5) and the feed address (6) change nothing.
- R3: In the control word, bit 0 is the enable, bits [3n+3:3n+1] hold the action of stage n, bits [15:13] hold the CPU pulse length and bits [18:16] hold the system pulse length. Its reset value is 0x7E008: disabled, stage 0 on full reset, stages 1 to 3 off, both lengths 7. The hold registers reset to DEF_HOLD, which is 1000. After reset all outputs are low.
- R4: A stage with hold H expires on the H-th clock edge after its count starts. The count starts at the enable edge, at the edge on which the stage is entered, or at the edge after a feed write. The output for its action rises one edge after the expiry.
- R5: The action codes are 0 off, 1 interrupt, 2 CPU reset pulse (cpu_rst_o), 3 system reset pulse (sys_rst_o) and 4 full reset pulse (all_rst_o).
- R6: When a stage expires, the sequence moves on the same edge to the nearest following stage whose action is not off. The search wraps from stage 3 to stage 0. Stages set to off take no time.
- R7: Writing 1 in bit 0 to address 6 restarts the sequence at stage 0 with a zero count. The restart takes effect one edge after the write edge. If that restart edge is also an expiry edge, the restart wins and no action fires.
- R8: A hold value of 0 behaves the same as a hold value of 1.
- R9: A CPU reset pulse lasts as many cycles as its length field. System and full reset pulses use the system length field. A length of 0 gives a pulse of one cycle.
- R10: The interrupt status (bit 0 at read address 9) is set by an interrupt action. It stays set until 1 is written to bit 0 of address 8. irq_o is the status ANDed with the enable bit, which is bit 0 of address 7.
- R11: Clearing the enable sends the sequence back to stage 0, and no action fires while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read data, valid one edge after rd_addr |
| irq_o | output | 1 | Interrupt line |
| cpu_rst_o | output | 1 | CPU reset request pulse |
| sys_rst_o | output | 1 | System reset request pulse |
| all_rst_o | output | 1 | Full reset request pulse |

## Verification
The feed restart and a stage expiry can land on the same edge. The bench provokes this by timing a feed write one edge before stage 0 reaches its hold count. It then expects the CPU pulse that would have followed to be absent, and the next pulse to arrive one full hold later. A scoreboard of expected output vectors, each tied to a cycle number, judges both the missing pulse and the late one.

// File: rtl/esc_wdt_pkg.sv
package esc_wdt_pkg;
  localparam int NSTG   = 4;
  localparam int SEL_W  = $clog2(NSTG);
  localparam int ACT_W  = 3;
  localparam int LEN_W  = 3;
  localparam int CPU_LSB = 1 + NSTG * ACT_W;
  localparam int SYS_LSB = CPU_LSB + LEN_W;
  localparam int CTRL_W  = SYS_LSB + LEN_W;

  typedef enum logic [ACT_W-1:0] {
    ACT_OFF = 3'd0,
    ACT_IRQ = 3'd1,
    ACT_CPU = 3'd2,
    ACT_SYS = 3'd3,
    ACT_ALL = 3'd4
  } act_e;

  localparam logic [31:0] UNLOCK_KEY = 32'h50D8_3AA1;

  localparam logic [3:0] A_KEY   = 4'd0;
  localparam logic [3:0] A_CTRL  = 4'd1;
  localparam logic [3:0] A_HOLD0 = 4'd2;
  localparam logic [3:0] A_FEED  = 4'd6;
  localparam logic [3:0] A_IEN   = 4'd7;
  localparam logic [3:0] A_ICLR  = 4'd8;
  localparam logic [3:0] A_IST   = 4'd9;

  function automatic logic act_live(input logic [ACT_W-1:0] a);
    return (a >= ACT_W'(1)) && (a <= ACT_W'(4));
  endfunction
endpackage

// File: rtl/esc_wdt_regs.sv
module esc_wdt_regs
  import esc_wdt_pkg::*;
#(
  parameter int HOLD_W = 16,
  parameter logic [HOLD_W-1:0] DEF_HOLD = 1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [3:0]                   wr_addr,
  input  logic [31:0]                  wr_data,
  output logic                         unlocked,
  output logic [CTRL_W-1:0]            ctrl_q,
  output logic [NSTG-1:0][HOLD_W-1:0]  hold_q,
  output logic                         feed_stb,
  output logic                         int_ena,
  output logic                         iclr_stb
);
  localparam logic [CTRL_W-1:0] CTRL_DEF =
    {3'd7, 3'd7, 3'd0, 3'd0, 3'd0, 3'd4, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      ctrl_q   <= CTRL_DEF;
      feed_stb <= 1'b0;
      int_ena  <= 1'b0;
      iclr_stb <= 1'b0;
    end else begin
      feed_stb <= 1'b0;
      iclr_stb <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          A_KEY:  unlocked <= (wr_data == UNLOCK_KEY);
          A_CTRL: if (unlocked) ctrl_q <= wr_data[CTRL_W-1:0];
          A_FEED: if (unlocked) feed_stb <= wr_data[0];
          A_IEN:  int_ena <= wr_data[0];
          A_ICLR: iclr_stb <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)
        hold_q[g] <= DEF_HOLD;
      else if (wr_en && unlocked && (wr_addr == A_HOLD0 + 4'(g)))
        hold_q[g] <= wr_data[HOLD_W-1:0];
    end
  end
endmodule

// File: rtl/esc_wdt_seq.sv
module esc_wdt_seq
  import esc_wdt_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en,
  input  logic [NSTG-1:0][ACT_W-1:0]        act,
  input  logic [NSTG-1:0][HOLD_W-1:0]       hold,
  input  logic                              feed,
  output logic [SEL_W-1:0]                  stage,
  output logic                              fire_irq,
  output logic                              fire_cpu,
  output logic                              fire_sys,
  output logic                              fire_all
);
  logic [HOLD_W-1:0] cnt, lim;
  logic [NSTG-1:0]   live;
  logic [SEL_W-1:0]  nxt;

  always_comb begin
    logic [SEL_W-1:0] idx;
    for (int i = 0; i < NSTG; i++) live[i] = act_live(act[i]);
    lim = (hold[stage] == '0) ? '0 : hold[stage] - HOLD_W'(1);
    nxt = stage;
    for (int k = NSTG - 1; k >= 1; k--) begin
      idx = stage + SEL_W'(k);
      if (live[idx]) nxt = idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= '0;
      cnt      <= '0;
      fire_irq <= 1'b0;
      fire_cpu <= 1'b0;
      fire_sys <= 1'b0;
      fire_all <= 1'b0;
    end else begin
      fire_irq <= 1'b0;
      fire_cpu <= 1'b0;
      fire_sys <= 1'b0;
      fire_all <= 1'b0;
      if (feed || !en) begin
        stage <= '0;
        cnt   <= '0;
      end else if (!live[stage]) begin
        if (|live) stage <= nxt;
        cnt <= '0;
      end else if (cnt >= lim) begin
        case (act_e'(act[stage]))
          ACT_IRQ: fire_irq <= 1'b1;
          ACT_CPU: fire_cpu <= 1'b1;
          ACT_SYS: fire_sys <= 1'b1;
          ACT_ALL: fire_all <= 1'b1;
          default: ;
        endcase
        stage <= nxt;
        cnt   <= '0;
      end else begin
        cnt <= cnt + HOLD_W'(1);
      end
    end
  end
endmodule

// File: rtl/esc_wdt_pulse.sv
module esc_wdt_pulse #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             pulse
);
  logic [LEN_W-1:0] rem, ld;

  assign ld = (len == '0) ? LEN_W'(1) : len;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      pulse <= 1'b0;
    end else if (trig) begin
      rem   <= ld;
      pulse <= 1'b1;
    end else begin
      pulse <= (rem > LEN_W'(1));
      if (rem != '0) rem <= rem - LEN_W'(1);
    end
  end
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
  import esc_wdt_pkg::*;
#(
  parameter int HOLD_W = 16,
  parameter logic [HOLD_W-1:0] DEF_HOLD = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o,
  output logic        all_rst_o
);
  localparam int NPULSE = 3;

  logic                         unlocked, feed_stb, int_ena, iclr_stb;
  logic [CTRL_W-1:0]            ctrl_q;
  logic [NSTG-1:0][HOLD_W-1:0]  hold_q;
  logic [NSTG-1:0][ACT_W-1:0]   act;
  logic [SEL_W-1:0]             stage;
  logic                         fire_irq, fire_cpu, fire_sys, fire_all;
  logic                         int_st, st_nxt;
  logic [NPULSE-1:0]            trig_v, out_v;
  logic [NPULSE-1:0][LEN_W-1:0] len_v;

  esc_wdt_regs #(.HOLD_W(HOLD_W), .DEF_HOLD(DEF_HOLD)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlocked(unlocked), .ctrl_q(ctrl_q), .hold_q(hold_q), .feed_stb(feed_stb),
    .int_ena(int_ena), .iclr_stb(iclr_stb)
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_act
    assign act[s] = ctrl_q[1 + s*ACT_W +: ACT_W];
  end

  esc_wdt_seq #(.HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst(rst), .en(ctrl_q[0]), .act(act), .hold(hold_q),
    .feed(feed_stb), .stage(stage), .fire_irq(fire_irq), .fire_cpu(fire_cpu),
    .fire_sys(fire_sys), .fire_all(fire_all)
  );

  assign trig_v = {fire_all, fire_sys, fire_cpu};
  assign len_v  = {ctrl_q[SYS_LSB +: LEN_W], ctrl_q[SYS_LSB +: LEN_W],
                   ctrl_q[CPU_LSB +: LEN_W]};

  for (genvar p = 0; p < NPULSE; p++) begin : g_pulse
    esc_wdt_pulse #(.LEN_W(LEN_W)) u_pulse (
      .clk(clk), .rst(rst), .trig(trig_v[p]), .len(len_v[p]), .pulse(out_v[p])
    );
  end

  assign cpu_rst_o = out_v[0];
  assign sys_rst_o = out_v[1];
  assign all_rst_o = out_v[2];

  // a new interrupt event takes precedence over a clear in the same cycle
  assign st_nxt = fire_irq | (int_st & ~iclr_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_st <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      int_st <= st_nxt;
      irq_o  <= st_nxt & int_ena;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        A_KEY:  rd_data <= {31'b0, unlocked};
        A_CTRL: rd_data <= 32'(ctrl_q);
        A_IEN:  rd_data <= {31'b0, int_ena};
        A_IST:  rd_data <= {31'b0, int_st};
        default:
          if (rd_addr >= A_HOLD0 && rd_addr < A_HOLD0 + 4'(NSTG))
            rd_data <= 32'(hold_q[rd_addr[SEL_W-1:0] - SEL_W'(A_HOLD0)]);
      endcase
    end
  end
endmodule

// File: rtl/esc_wdt_chk.sv
module esc_wdt_chk
  import esc_wdt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              unlocked,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              feed_stb,
  input logic [SEL_W-1:0]  stage,
  input logic              fire_irq,
  input logic              fire_cpu,
  input logic              fire_sys,
  input logic              fire_all,
  input logic              cpu_rst_o,
  input logic              int_st
);
  logic fire_any;
  assign fire_any = fire_irq | fire_cpu | fire_sys | fire_all;

  assert_locked_cfg_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(unlocked) |-> $stable(ctrl_q));

  assert_feed_restart_R7: assert property (@(posedge clk) disable iff (rst)
    $past(feed_stb) |-> (stage == '0) && !fire_any);

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_q[0]) |-> (stage == '0) && !fire_any);

  assert_cpu_pulse_src_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rst_o) |-> $past(fire_cpu));

  assert_irq_status_src_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(int_st) |-> $past(fire_irq));
endmodule

bind esc_watchdog esc_wdt_chk u_chk (
  .clk(clk), .rst(rst), .unlocked(unlocked), .ctrl_q(ctrl_q),
  .feed_stb(feed_stb), .stage(stage), .fire_irq(fire_irq),
  .fire_cpu(fire_cpu), .fire_sys(fire_sys), .fire_all(fire_all),
  .cpu_rst_o(cpu_rst_o), .int_st(int_st)
);

// File: tb/tb_esc_watchdog.sv
`timescale 1ns/1ps
module tb_esc_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o, cpu_rst_o, sys_rst_o, all_rst_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  typedef struct { int at; logic [3:0] v; string tag; } exp_t;
  exp_t sbq[$];

  esc_watchdog dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o),
    .sys_rst_o(sys_rst_o), .all_rst_o(all_rst_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: outputs as {irq, cpu, sys, all}
  always @(negedge clk) begin
    if (!rst && sbq.size() != 0) begin
      if (sbq[0].at == cyc) begin
        check({irq_o, cpu_rst_o, sys_rst_o, all_rst_o} === sbq[0].v, sbq[0].tag,
              32'({irq_o, cpu_rst_o, sys_rst_o, all_rst_o}), 32'(sbq[0].v));
        void'(sbq.pop_front());
      end else if (sbq[0].at < cyc) begin
        check(1'b0, {sbq[0].tag, " missed"}, 32'(cyc), 32'(sbq[0].at));
        void'(sbq.pop_front());
      end
    end
  end

  task automatic expect_at(input int at, input logic [3:0] v, input string tag);
    exp_t e;
    e.at = at; e.v = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  // called at a negedge; the write lands on the next edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input logic [2:0] a0, a1, a2, a3,
                                          input logic [2:0] cl, sl);
    return {13'b0, sl, cl, a3, a2, a1, a0, en};
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    report();
  end

  initial begin
    logic [31:0] d;
    int e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check({irq_o, cpu_rst_o, sys_rst_o, all_rst_o} === 4'b0, "R3 outputs after reset",
          32'({irq_o, cpu_rst_o, sys_rst_o, all_rst_o}), 0);
    rd(4'd0, d); check(d === 32'd0, "R1 locked after reset", d, 0);
    rd(4'd1, d); check(d === 32'h7E008, "R3 control default", d, 32'h7E008);
    rd(4'd2, d); check(d === 32'd1000, "R3 hold default", d, 1000);

    // locked writes dropped
    wr(4'd1, mk_ctrl(1, 1, 0, 0, 0, 0, 0));
    wr(4'd2, 32'd5);
    rd(4'd1, d); check(d === 32'h7E008, "R2 control locked", d, 32'h7E008);
    rd(4'd2, d); check(d === 32'd1000, "R2 hold locked", d, 1000);

    wr(4'd0, 32'h50D8_3AA1);
    rd(4'd0, d); check(d === 32'd1, "R1 unlocked by key", d, 1);

    // escalation: irq, cpu(len3), off, sys(len2)
    wr(4'd7, 32'd1);
    wr(4'd2, 32'd5);
    wr(4'd3, 32'd4);
    wr(4'd5, 32'd3);
    wr(4'd1, mk_ctrl(1, 1, 2, 0, 3, 3, 2));
    e = cyc;
    expect_at(e + 5,  4'b0000, "R4 no irq before expiry");
    expect_at(e + 6,  4'b1000, "R4 R5 irq after stage 0");
    expect_at(e + 9,  4'b1000, "R4 cpu not yet");
    expect_at(e + 10, 4'b1100, "R5 cpu pulse start");
    expect_at(e + 12, 4'b1100, "R9 cpu pulse third cycle");
    expect_at(e + 13, 4'b1010, "R6 R9 stage 2 skipped, sys starts, cpu ends");
    expect_at(e + 14, 4'b1010, "R9 sys pulse second cycle");
    expect_at(e + 15, 4'b1000, "R9 sys pulse ends");
    drain();
    rd(4'd9, d); check(d === 32'd1, "R10 status set", d, 1);
    wr(4'd1, mk_ctrl(0, 1, 2, 0, 3, 3, 2));
    wr(4'd8, 32'd1);
    e = cyc;
    expect_at(e + 2,  4'b0000, "R10 irq cleared");
    expect_at(e + 10, 4'b0000, "R11 quiet while disabled");
    expect_at(e + 30, 4'b0000, "R11 quiet while disabled later");
    drain();
    rd(4'd9, d); check(d === 32'd0, "R10 status cleared", d, 0);

    // feed behaviour, stage 0 cpu only, hold 6, len 0
    wr(4'd2, 32'd6);
    wr(4'd1, mk_ctrl(1, 2, 0, 0, 0, 0, 0));
    e = cyc;
    expect_at(e + 7,  4'b0000, "R7 feed deferred expiry");
    expect_at(e + 12, 4'b0100, "R7 R6 expiry after feed, wrap to stage 0");
    expect_at(e + 13, 4'b0000, "R9 zero length gives one cycle");
    expect_at(e + 18, 4'b0000, "R7 feed wins over expiry");
    expect_at(e + 24, 4'b0100, "R2 locked feed ignored");
    expect_at(e + 25, 4'b0000, "R9 pulse ends");
    wait_until(e + 3);
    wr(4'd6, 32'd1);
    wait_until(e + 15);
    wr(4'd6, 32'd1);
    wr(4'd0, 32'd0);
    wait_until(e + 19);
    wr(4'd6, 32'd1);
    drain();
    rd(4'd0, d); check(d === 32'd0, "R1 relocked", d, 0);

    // hold of zero, full reset with sys length 4, then irq stage hold 50
    wr(4'd0, 32'h50D8_3AA1);
    wr(4'd1, mk_ctrl(0, 0, 0, 0, 0, 0, 0));
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd50);
    wr(4'd1, mk_ctrl(1, 4, 1, 0, 0, 0, 4));
    e = cyc;
    expect_at(e + 2,  4'b0001, "R8 R5 full pulse after one cycle");
    expect_at(e + 5,  4'b0001, "R9 full uses sys length");
    expect_at(e + 6,  4'b0000, "R9 full pulse ends");
    expect_at(e + 51, 4'b0000, "R4 stage 1 not yet");
    expect_at(e + 52, 4'b1000, "R4 R5 stage 1 irq");
    drain();
    wr(4'd1, mk_ctrl(0, 4, 1, 0, 0, 0, 4));
    wr(4'd7, 32'd0);
    @(negedge clk);
    check(irq_o === 1'b0, "R10 irq gated by enable", 32'(irq_o), 0);
    rd(4'd9, d); check(d === 32'd1, "R10 status kept while gated", d, 1);
    rd(4'd7, d); check(d === 32'd0, "R10 enable readback", d, 0);

    report();
  end
endmodule